// File: doc/BRIEF.md
# Stack and Next-PC Control Unit

This block handles the stack side of instruction execution and chooses the next program counter. A decoder supplies the instruction code. Alongside it come a flag that says whether the instruction's condition holds, the constant word carried by the instruction, the address of the following instruction, the current stack pointer, the register operand that a push stores, and the word that data memory returns. From these the block drives the address, write data and strobes of the data-memory port, and it works out the updated stack pointer and program counter.

The memory port is combinational, so a memory that answers in the same cycle can return its read word before the clock edge. The updated stack pointer and program counter are registered on that edge, together with a flag marking the cycle in which they were produced. The stack grows toward lower addresses, and the pointer always holds the address of the word on top. The data memory is outside the block.

Top module: `stack_pc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_out`, `sp_out` and `upd_valid` become zero.
- R2: Push (instruction code 4'hA) with `instr_valid` high drives `mem_wr`=1, `mem_rd`=0, `mem_addr`=`sp_in`-8 and `mem_wdata`=`src_val` in the same cycle. After the next edge `sp_out`=`sp_in`-8 and `pc_out`=`next_addr`.
- R3: Pop (code 4'hB) drives `mem_rd`=1, `mem_wr`=0 and `mem_addr`=`sp_in`, which is the old pointer. After the edge `sp_out`=`sp_in`+8 and `pc_out`=`next_addr`.
- R4: Call (code 4'h8) drives `mem_wr`=1, `mem_addr`=`sp_in`-8 and `mem_wdata`=`next_addr`. After the edge `sp_out`=`sp_in`-8 and `pc_out`=`const_val`.
- R5: Return (code 4'h9) drives `mem_rd`=1 and `mem_addr`=`sp_in`. After the edge `pc_out`=`mem_rdata`, the value returned in that cycle, and `sp_out`=`sp_in`+8.
- R6: Jump (code 4'h7) raises no strobe and leaves the pointer unchanged. `pc_out` becomes `const_val`, taken as an absolute address, when `cond_ok` is 1, and `next_addr` when it is 0.
- R7: Any other code raises no strobe. It gives `pc_out`=`next_addr` and `sp_out`=`sp_in`.
- R8: With `instr_valid` low, both strobes stay low whatever the code is. After the edge `upd_valid`=0, and `pc_out` and `sp_out` keep their previous values. With `instr_valid` high, `upd_valid`=1 after the edge.
- R9: At most one of `mem_rd` and `mem_wr` is high in any cycle. Every access is one 8-byte word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is present this cycle |
| icode | input | 4 | Decoded instruction code |
| cond_ok | input | 1 | Condition of the instruction holds |
| const_val | input | 64 | Constant word of the instruction (absolute target) |
| next_addr | input | 64 | Address of the following instruction |
| sp_in | input | 64 | Current stack pointer |
| src_val | input | 64 | Register operand stored by push |
| mem_rdata | input | 64 | Word read from data memory |
| mem_addr | output | 64 | Data-memory byte address |
| mem_wdata | output | 64 | Data-memory write word |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| sp_out | output | 64 | Updated stack pointer (registered) |
| pc_out | output | 64 | Next program counter (registered) |
| upd_valid | output | 1 | `sp_out`/`pc_out` were produced by a valid instruction |

## Verification
The memory-port outputs, `mem_addr`, `mem_wdata` and the strobes, are due in the same cycle as the instruction. The bench therefore drives each instruction on the falling edge and samples these outputs a quarter period later, before the rising edge. `sp_out`, `pc_out` and `upd_valid` are due one edge later, so they are sampled at the following falling edge, before the next instruction is applied. A behavioural model keeps the expected pointer, a word memory and a queue of return addresses. A return's new PC is checked against the address its matching call saved in that queue, so the round trip through memory is checked as well.

// File: rtl/stack_pc_pkg.sv
package stack_pc_pkg;

    localparam logic [3:0] CODE_JUMP = 4'h7;
    localparam logic [3:0] CODE_CALL = 4'h8;
    localparam logic [3:0] CODE_RET  = 4'h9;
    localparam logic [3:0] CODE_PUSH = 4'hA;
    localparam logic [3:0] CODE_POP  = 4'hB;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_DOWN = 2'd1,
        SP_UP   = 2'd2
    } sp_move_e;

    typedef enum logic [1:0] {
        PC_SEQ   = 2'd0,
        PC_CONST = 2'd1,
        PC_MEM   = 2'd2
    } pc_src_e;

    typedef enum logic [1:0] {
        WD_NONE  = 2'd0,
        WD_OPND  = 2'd1,
        WD_RETAD = 2'd2
    } wdata_src_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        sp_move_e   sp_move;
        pc_src_e    pc_src;
        wdata_src_e wd_src;
    } stk_ctl_t;

    function automatic stk_ctl_t decode_ctl(input logic valid,
                                            input logic [3:0] code,
                                            input logic cond);
        stk_ctl_t c;
        c = '{rd: 1'b0, wr: 1'b0, sp_move: SP_HOLD, pc_src: PC_SEQ, wd_src: WD_NONE};
        if (valid) begin
            case (code)
                CODE_JUMP: c.pc_src = cond ? PC_CONST : PC_SEQ;
                CODE_CALL: begin
                    c.wr = 1'b1; c.sp_move = SP_DOWN;
                    c.pc_src = PC_CONST; c.wd_src = WD_RETAD;
                end
                CODE_RET: begin
                    c.rd = 1'b1; c.sp_move = SP_UP; c.pc_src = PC_MEM;
                end
                CODE_PUSH: begin
                    c.wr = 1'b1; c.sp_move = SP_DOWN; c.wd_src = WD_OPND;
                end
                CODE_POP: begin
                    c.rd = 1'b1; c.sp_move = SP_UP;
                end
                default: c.pc_src = PC_SEQ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stack_pc_pkg::*;
(
    input  logic       valid,
    input  logic [3:0] code,
    input  logic       cond,
    output stk_ctl_t   ctl
);
    always_comb ctl = decode_ctl(valid, code, cond);

    // R9
    always_comb begin
        single_strobe_chk: assert ($onehot0({ctl.rd, ctl.wr}));
    end
endmodule

// File: rtl/stk_mem_port.sv
module stk_mem_port
    import stack_pc_pkg::*;
#(
    parameter int W = 64,
    parameter int SLOT_BYTES = W / 8
) (
    input  stk_ctl_t       ctl,
    input  logic [W-1:0]   sp,
    input  logic [W-1:0]   opnd,
    input  logic [W-1:0]   ret_addr,
    output logic [W-1:0]   addr,
    output logic [W-1:0]   wdata,
    output logic           rd,
    output logic           wr
);
    localparam logic [W-1:0] SLOT = W'(SLOT_BYTES);

    logic [W-1:0] sp_dec;
    assign sp_dec = sp - SLOT;

    always_comb begin
        rd    = ctl.rd;
        wr    = ctl.wr;
        addr  = (ctl.sp_move == SP_DOWN) ? sp_dec : sp;
        case (ctl.wd_src)
            WD_OPND:  wdata = opnd;
            WD_RETAD: wdata = ret_addr;
            default:  wdata = '0;
        endcase
    end
endmodule

// File: rtl/stk_next_state.sv
module stk_next_state
    import stack_pc_pkg::*;
#(
    parameter int W = 64,
    parameter int SLOT_BYTES = W / 8
) (
    input  stk_ctl_t       ctl,
    input  logic [W-1:0]   sp,
    input  logic [W-1:0]   konst,
    input  logic [W-1:0]   seq_addr,
    input  logic [W-1:0]   rdata,
    output logic [W-1:0]   sp_nxt,
    output logic [W-1:0]   pc_nxt
);
    localparam logic [W-1:0] SLOT = W'(SLOT_BYTES);

    always_comb begin
        case (ctl.sp_move)
            SP_DOWN: sp_nxt = sp - SLOT;
            SP_UP:   sp_nxt = sp + SLOT;
            default: sp_nxt = sp;
        endcase
        case (ctl.pc_src)
            PC_CONST: pc_nxt = konst;
            PC_MEM:   pc_nxt = rdata;
            default:  pc_nxt = seq_addr;
        endcase
    end
endmodule

// File: rtl/stack_pc_ctrl.sv
module stack_pc_ctrl
    import stack_pc_pkg::*;
#(
    parameter int W = 64,
    parameter int SLOT_BYTES = W / 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         instr_valid,
    input  logic [3:0]   icode,
    input  logic         cond_ok,
    input  logic [W-1:0] const_val,
    input  logic [W-1:0] next_addr,
    input  logic [W-1:0] sp_in,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] sp_out,
    output logic [W-1:0] pc_out,
    output logic         upd_valid
);
    localparam logic [W-1:0] SLOT = W'(SLOT_BYTES);

    stk_ctl_t     ctl;
    logic [W-1:0] sp_nxt;
    logic [W-1:0] pc_nxt;

    stk_decode u_dec (
        .valid (instr_valid),
        .code  (icode),
        .cond  (cond_ok),
        .ctl   (ctl)
    );

    stk_mem_port #(.W(W), .SLOT_BYTES(SLOT_BYTES)) u_port (
        .ctl      (ctl),
        .sp       (sp_in),
        .opnd     (src_val),
        .ret_addr (next_addr),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .rd       (mem_rd),
        .wr       (mem_wr)
    );

    stk_next_state #(.W(W), .SLOT_BYTES(SLOT_BYTES)) u_nxt (
        .ctl      (ctl),
        .sp       (sp_in),
        .konst    (const_val),
        .seq_addr (next_addr),
        .rdata    (mem_rdata),
        .sp_nxt   (sp_nxt),
        .pc_nxt   (pc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_out    <= '0;
            pc_out    <= '0;
            upd_valid <= 1'b0;
        end else begin
            upd_valid <= instr_valid;
            if (instr_valid) begin
                sp_out <= sp_nxt;
                pc_out <= pc_nxt;
            end
        end
    end

    // R2 R4
    write_sp_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (sp_out == $past(mem_addr)));

    // R3 R5
    read_sp_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (sp_out == $past(mem_addr) + SLOT));

    // R5
    ret_target_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && icode == CODE_RET) |=> (pc_out == $past(mem_rdata)));

    // R6
    jump_untaken_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && icode == CODE_JUMP && !cond_ok) |=> (pc_out == $past(next_addr)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!upd_valid && $stable(pc_out) && $stable(sp_out)));

    // R8
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/stack_pc_ctrl_tb.sv
module stack_pc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [3:0]  icode;
    logic        cond_ok;
    logic [63:0] const_val, next_addr, sp_in, src_val, mem_rdata;
    logic [63:0] mem_addr, mem_wdata, sp_out, pc_out;
    logic        mem_rd, mem_wr, upd_valid;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [63:0] model_mem [logic [63:0]];
    logic [63:0] ret_q [$];
    logic [63:0] m_sp, m_pc;

    always #10 clk = ~clk;

    stack_pc_ctrl u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .icode(icode),
        .cond_ok(cond_ok), .const_val(const_val), .next_addr(next_addr),
        .sp_in(sp_in), .src_val(src_val), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .sp_out(sp_out), .pc_out(pc_out), .upd_valid(upd_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic v, input logic [3:0] op,
                        input logic c, input logic [63:0] k, input logic [63:0] nx,
                        input logic [63:0] src);
        logic e_rd, e_wr;
        logic [63:0] e_addr, e_wd, e_sp, e_pc;
        e_rd = 0; e_wr = 0; e_addr = 0; e_wd = 0;
        e_sp = m_sp; e_pc = nx;
        if (v) begin
            case (op)
                4'h7: e_pc = c ? k : nx;
                4'h8: begin e_wr = 1; e_addr = m_sp - 8; e_wd = nx; e_sp = m_sp - 8; e_pc = k; end
                4'h9: begin e_rd = 1; e_addr = m_sp; e_sp = m_sp + 8;
                            e_pc = (ret_q.size() > 0) ? ret_q.pop_back() : 64'h0; end
                4'hA: begin e_wr = 1; e_addr = m_sp - 8; e_wd = src; e_sp = m_sp - 8; end
                4'hB: begin e_rd = 1; e_addr = m_sp; e_sp = m_sp + 8; end
                default: ;
            endcase
            if (op == 4'h8) ret_q.push_back(nx);
        end else begin
            e_pc = m_pc;
        end
        instr_valid = v; icode = op; cond_ok = c; const_val = k;
        next_addr = nx; src_val = src; sp_in = m_sp;
        mem_rdata = (e_rd && model_mem.exists(e_addr)) ? model_mem[e_addr] : 64'h0;
        #5;
        chk({req, " rd strobe"}, {63'h0, mem_rd}, {63'h0, e_rd});
        chk({req, " wr strobe"}, {63'h0, mem_wr}, {63'h0, e_wr});
        if (e_rd || e_wr) chk({req, " addr"}, mem_addr, e_addr);
        if (e_wr) chk({req, " wdata"}, mem_wdata, e_wd);
        @(posedge clk);
        if (mem_wr) model_mem[mem_addr] = mem_wdata;
        @(negedge clk);
        chk({req, " upd_valid"}, {63'h0, upd_valid}, {63'h0, v});
        chk({req, " sp_out"}, sp_out, e_sp);
        chk({req, " pc_out"}, pc_out, e_pc);
        m_sp = e_sp; m_pc = e_pc;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; instr_valid = 0; icode = 0; cond_ok = 0; const_val = 0;
        next_addr = 0; sp_in = 0; src_val = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_out, 64'h0);
        chk("R1 sp", sp_out, 64'h0);
        chk("R1 valid", {63'h0, upd_valid}, 64'h0);
        rst = 0;
        m_sp = 64'h1000; m_pc = 64'h0;

        step("R2 push", 1, 4'hA, 0, 64'h0, 64'h0002, 64'hDEAD_BEEF_0000_0001);
        step("R4 call", 1, 4'h8, 0, 64'h0400, 64'h000B, 64'h0);
        step("R2 push inner", 1, 4'hA, 0, 64'h0, 64'h0402, 64'h1234_5678_9ABC_DEF0);
        step("R4 call nested", 1, 4'h8, 0, 64'h0800, 64'h040B, 64'h0);
        step("R6 jump taken", 1, 4'h7, 1, 64'h0900, 64'h0809, 64'h0);
        step("R6 jump untaken", 1, 4'h7, 0, 64'h0A00, 64'h0909, 64'h0);
        step("R7 other code", 1, 4'h6, 1, 64'h0BBB, 64'h090B, 64'h0);
        step("R7 nop code", 1, 4'h1, 1, 64'h0CCC, 64'h090C, 64'h0);
        step("R8 idle push", 0, 4'hA, 0, 64'h0, 64'h0555, 64'hFFFF);
        step("R8 idle call", 0, 4'h8, 1, 64'h0777, 64'h0666, 64'h0);
        step("R5 ret nested", 1, 4'h9, 0, 64'h0, 64'h0910, 64'h0);
        step("R3 pop inner", 1, 4'hB, 0, 64'h0, 64'h040D, 64'h0);
        chk("R3 pop data", mem_rdata, 64'h1234_5678_9ABC_DEF0);
        step("R5 ret outer", 1, 4'h9, 0, 64'h0, 64'h040F, 64'h0);
        step("R3 pop outer", 1, 4'hB, 0, 64'h0, 64'h000D, 64'h0);
        chk("R3 pop outer data", mem_rdata, 64'hDEAD_BEEF_0000_0001);
        chk("R3 sp back home", m_sp, 64'h1000);
        // R9: call / ret run near address zero to check wrap of the pointer
        m_sp = 64'h0;
        step("R4 call wrap", 1, 4'h8, 0, 64'h0F00, 64'h0013, 64'h0);
        step("R5 ret wrap", 1, 4'h9, 0, 64'h0, 64'h0F09, 64'h0);
        // R9 back-to-back accesses keep a single strobe
        for (int i = 0; i < 4; i++)
            step("R9 push run", 1, 4'hA, 0, 64'h0, 64'(i * 2), 64'(i + 100));
        for (int i = 0; i < 4; i++)
            step("R9 pop run", 1, 4'hB, 0, 64'h0, 64'(i * 2 + 1), 64'h0);
        rst = 1;
        @(negedge clk);
        chk("R1 re-reset pc", pc_out, 64'h0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule